// File: doc/BRIEF.md
# Serial DAC Command Sequencer

This block is the host side of a three-wire link to a dual 8-bit voltage DAC. It accepts a request, builds a 16-bit command word from it, and shifts the word out in clock mode 0: the serial clock rests low, the data line moves only on the clock's falling edge, and the receiver samples on the rising edge. It can also follow the frame with a timed pulse on the asynchronous load line. The request carries a two-bit channel mask, an 8-bit value, an update-enable, a deferred-load select, a power-down select and a framing mode. In one mode the word goes out as a single burst of sixteen clocks. In the other it goes out as two bursts of eight clocks, with a pause between them while chip select stays low.

Every timing limit of the link is a minimum, and each is counted in system clock cycles set by a parameter: clock high and low time, chip-select setup, the chip-select high gap, the delay from chip-select rise to the load pulse, the load pulse width, the pause between bytes, and the settling wait after power-up. One state machine runs the sequence. From reset it waits in PWRUP until the settling wait ends, then moves to IDLE. A request in IDLE goes to SETUP (chip select low). SETUP leads to alternating HIGH and LOW clock phases. In split mode, the HIGH phase of the eighth bit leads to PAUSE and PAUSE leads to LOW. The HIGH phase of the last bit leads to TAIL, and TAIL to RECOVER (chip select high). RECOVER goes to LDPULSE when a deferred update was asked for and otherwise to DONE. LDPULSE goes to DONE, and DONE returns to IDLE. A one-cycle done flag marks the end of each sequence. Requests that arrive while the block is busy are dropped.

Top module: `dac_cmd_seq`

## Requirements
- R1: After reset, cs_n=1, sclk=0, load_n=1, done=0 and busy=1. busy stays high, and no frame starts, for PWRUP_CYC cycles after reset is released. busy reads 0 from cycle PWRUP_CYC+1 on.
- R2: Each frame has exactly 16 rising sclk edges. The bits sent, most significant first, are: bits 15..13 = 0, bit 12 = power-down, bit 11 = update, bit 10 = deferred, bit 9 = channel B (mask bit 1), bit 8 = channel A (mask bit 0), bits 7..0 = value.
- R3: sclk is 0 whenever cs_n is 1. mosi never changes while sclk is 1 or on the cycle sclk rises, so it changes only on a falling edge or while sclk is low.
- R4: Every sclk high phase lasts exactly HALF_CYC cycles. Every low phase between two bits lasts exactly HALF_CYC cycles, except the split-mode pause named in R6.
- R5: The first sclk rise comes exactly CSS_CYC cycles after cs_n falls. cs_n rises exactly HALF_CYC cycles after the last sclk fall.
- R6: In split mode (req_split=1), the low phase after the eighth rising edge lasts PAUSE_CYC+HALF_CYC cycles, and cs_n stays low across it.
- R7: When update and deferred are both 1, load_n goes low max(CSW_CYC, LD_GAP_CYC) cycles after cs_n rises and stays low for exactly LD_W_CYC cycles. Otherwise load_n stays 1 for the whole sequence.
- R8: Between two frames, cs_n stays high for at least CSW_CYC cycles.
- R9: done is a single-cycle pulse, one per accepted request, and comes after cs_n has risen and any load pulse has ended. busy is 1 from the cycle after acceptance through the done cycle, and 0 on the cycle after done.
- R10: A req_valid that arrives while busy=1 is dropped. It starts no frame and does not change the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_chan | input | 2 | Channel mask: bit 0 = channel A, bit 1 = channel B |
| req_value | input | 8 | Value for the addressed channels |
| req_update | input | 1 | Move input registers to output registers |
| req_defer | input | 1 | Defer that move to the load pulse |
| req_pdown | input | 1 | Power down the addressed channels |
| req_split | input | 1 | 1 = two 8-clock bursts with a pause, 0 = one 16-clock burst |
| busy | output | 1 | Sequence in progress, or power-up wait |
| done | output | 1 | One-cycle end-of-sequence flag |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data, most significant bit first |
| load_n | output | 1 | Active-low asynchronous load pulse |

## Verification
A wrong state or a wrong phase counter shows at the pins within one phase. The phase is either too long or too short, which makes a setup, high, low or tail width differ from its exact expected count. A bad bit index shows at the end of the same frame, as a rising-edge count other than sixteen, a missing or misplaced pause, or a shifted word. A bad latch of the deferred flag shows a few cycles after chip select rises, as a missing load pulse, an extra one, or one of the wrong width or delay.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    localparam int unsigned CMD_W  = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned CH_N   = 2;

    // control field positions inside the command word (decoded by the DAC)
    localparam int unsigned POS_PD  = 12;
    localparam int unsigned POS_UPD = 11;
    localparam int unsigned POS_DEF = 10;
    localparam int unsigned POS_CH  = 8;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_PAUSE,
        ST_TAIL,
        ST_RECOVER,
        ST_LDPULSE,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/dac_word_pack.sv
module dac_word_pack
    import dac_seq_pkg::*;
(
    input  logic [CH_N-1:0]   chan_mask,
    input  logic [DATA_W-1:0] value,
    input  logic              upd,
    input  logic              defer,
    input  logic              pdown,
    output logic [CMD_W-1:0]  word
);

    always_comb begin
        word                  = '0;
        word[DATA_W-1:0]      = value;
        word[POS_CH +: CH_N]  = chan_mask;
        word[POS_DEF]         = defer;
        word[POS_UPD]         = upd;
        word[POS_PD]          = pdown;
    end

endmodule

// File: rtl/dac_tick_timer.sv
module dac_tick_timer #(
    parameter int unsigned TW      = 10,
    parameter int unsigned RST_LEN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= TW'(RST_LEN - 1);
        end else if (load) begin
            cnt <= load_val - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R4: a phase of zero length would wrap the counter
    always @(posedge clk) begin
        if (rst_n && load) begin
            a_r4_phase_nonzero: assert (load_val != '0)
                else $error("phase length of zero loaded");
        end
    end

endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
    parameter int unsigned W  = 16,
    parameter int unsigned IW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  word,
    input  logic          shift,
    output logic          bit_out,
    output logic [IW-1:0] idx
);

    logic [W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            idx  <= '0;
        end else if (load) begin
            sreg <= word;
            idx  <= '0;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
            idx  <= idx + 1'b1;
        end
    end

    assign bit_out = sreg[W-1];

    // R2: never shift beyond the frame
    a_r2_no_overshift: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (idx < IW'(W)))
        else $error("shift past end of frame");

endmodule

// File: rtl/dac_cmd_seq.sv
module dac_cmd_seq
    import dac_seq_pkg::*;
#(
    parameter int unsigned HALF_CYC   = 8,
    parameter int unsigned CSS_CYC    = 6,
    parameter int unsigned CSW_CYC    = 8,
    parameter int unsigned LD_GAP_CYC = 10,
    parameter int unsigned LD_W_CYC   = 10,
    parameter int unsigned PAUSE_CYC  = 16,
    parameter int unsigned PWRUP_CYC  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_chan,
    input  logic [7:0] req_value,
    input  logic       req_update,
    input  logic       req_defer,
    input  logic       req_pdown,
    input  logic       req_split,
    output logic       busy,
    output logic       done,
    output logic       sclk,
    output logic       cs_n,
    output logic       mosi,
    output logic       load_n
);

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    localparam int unsigned REC_LD_CYC = umax(CSW_CYC, LD_GAP_CYC);
    localparam int unsigned MAX_DUR    = umax(umax(umax(HALF_CYC, CSS_CYC), umax(REC_LD_CYC, LD_W_CYC)),
                                              umax(PAUSE_CYC, PWRUP_CYC));
    localparam int unsigned TW         = $clog2(MAX_DUR + 1);
    localparam int unsigned IW         = $clog2(CMD_W + 1);

    seq_state_t       state, nxt;
    logic             accept;
    logic             split_q, pulse_q;
    logic             tmr_load, tmr_exp;
    logic [TW-1:0]    tmr_val;
    logic [CMD_W-1:0] cmd_word;
    logic             sh_shift;
    logic [IW-1:0]    bit_idx;
    logic             last_bit, byte_end;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign last_bit = (bit_idx == IW'(CMD_W - 1));
    assign byte_end = (bit_idx == IW'(DATA_W - 1));
    assign sh_shift = (state == ST_HIGH) && tmr_exp;

    dac_word_pack u_pack (
        .chan_mask (req_chan),
        .value     (req_value),
        .upd       (req_update),
        .defer     (req_defer),
        .pdown     (req_pdown),
        .word      (cmd_word)
    );

    dac_frame_shifter #(.W(CMD_W), .IW(IW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .word    (cmd_word),
        .shift   (sh_shift),
        .bit_out (mosi),
        .idx     (bit_idx)
    );

    dac_tick_timer #(.TW(TW), .RST_LEN(PWRUP_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // request options held for the whole sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            split_q <= 1'b0;
            pulse_q <= 1'b0;
        end else if (accept) begin
            split_q <= req_split;
            pulse_q <= req_update & req_defer;
        end
    end

    // length of each state in clock cycles
    always_comb begin
        unique case (nxt)
            ST_PWRUP:   tmr_val = TW'(PWRUP_CYC);
            ST_SETUP:   tmr_val = TW'(CSS_CYC);
            ST_HIGH,
            ST_LOW,
            ST_TAIL:    tmr_val = TW'(HALF_CYC);
            ST_PAUSE:   tmr_val = TW'(PAUSE_CYC);
            ST_RECOVER: tmr_val = pulse_q ? TW'(REC_LD_CYC) : TW'(CSW_CYC);
            ST_LDPULSE: tmr_val = TW'(LD_W_CYC);
            default:    tmr_val = TW'(1);
        endcase
    end

    assign tmr_load = (nxt != state);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PWRUP:   if (tmr_exp) nxt = ST_IDLE;
            ST_IDLE:    if (req_valid) nxt = ST_SETUP;
            ST_SETUP:   if (tmr_exp) nxt = ST_HIGH;
            ST_HIGH: begin
                if (tmr_exp) begin
                    if (last_bit)                nxt = ST_TAIL;
                    else if (split_q && byte_end) nxt = ST_PAUSE;
                    else                         nxt = ST_LOW;
                end
            end
            ST_LOW:     if (tmr_exp) nxt = ST_HIGH;
            ST_PAUSE:   if (tmr_exp) nxt = ST_LOW;
            ST_TAIL:    if (tmr_exp) nxt = ST_RECOVER;
            ST_RECOVER: if (tmr_exp) nxt = pulse_q ? ST_LDPULSE : ST_DONE;
            ST_LDPULSE: if (tmr_exp) nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= nxt;
    end

    // registered outputs, aligned with the state they belong to
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            load_n <= 1'b1;
            done   <= 1'b0;
            busy   <= 1'b1;
        end else begin
            sclk   <= (nxt == ST_HIGH);
            cs_n   <= !((nxt == ST_SETUP) || (nxt == ST_HIGH) || (nxt == ST_LOW) ||
                        (nxt == ST_PAUSE) || (nxt == ST_TAIL));
            load_n <= (nxt != ST_LDPULSE);
            done   <= (nxt == ST_DONE);
            busy   <= (nxt != ST_IDLE);
        end
    end

    // R1: nothing moves on the link during the power-up wait
    a_r1_quiet_in_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWRUP) |-> (cs_n && busy && !sclk))
        else $error("link active during power-up wait");

    // R3: clock only inside a frame
    a_r3_clock_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n)
        else $error("sclk high with chip select released");

    // R3: data steady while clock is high
    a_r3_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi))
        else $error("mosi moved while sclk high");

    // R6: pause keeps chip select low with the clock at rest
    a_r6_pause_holds_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE) |-> (!cs_n && !sclk))
        else $error("pause without chip select held");

    // R7: load pulse only with chip select high
    a_r7_load_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> cs_n)
        else $error("load pulse inside a frame");

    // R9: done lasts one cycle
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one cycle");

endmodule

// File: tb/sim_dac_cmd_seq.sv
module sim_dac_cmd_seq;

    localparam int HALF  = 8;
    localparam int CSS   = 6;
    localparam int CSW   = 8;
    localparam int LDG   = 10;
    localparam int LDW   = 10;
    localparam int PAUSE = 16;
    localparam int PWR   = 1000;
    localparam int REC   = (LDG > CSW) ? LDG : CSW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_chan = '0;
    logic [7:0] req_value = '0;
    logic       req_update = 1'b0, req_defer = 1'b0, req_pdown = 1'b0, req_split = 1'b0;
    logic       busy, done, sclk, cs_n, mosi, load_n;

    dac_cmd_seq #(
        .HALF_CYC(HALF), .CSS_CYC(CSS), .CSW_CYC(CSW), .LD_GAP_CYC(LDG),
        .LD_W_CYC(LDW), .PAUSE_CYC(PAUSE), .PWRUP_CYC(PWR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_value(req_value), .req_update(req_update), .req_defer(req_defer),
        .req_pdown(req_pdown), .req_split(req_split), .busy(busy), .done(done),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .load_n(load_n)
    );

    always #2.5ns clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_ge(string tag, int act, int lo);
        n_cmp++;
        if (act < lo) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lo);
        end
    endtask

    // ---------------- port monitor ----------------
    int cyc = 0, frames = 0, dones = 0;
    int t_csf = 0, t_csr = 0, t_rise = 0, t_fall = 0, t_ldf = 0;
    int nrise = 0, dly = 0, hi_min = 0, hi_max = 0, lo8 = 0, lo_min = 0, lo_max = 0;
    int tail = 0, ldgap = 0, ldw = 0, nld = 0, done_run = 0, done_w = 0;
    int mosi_bad = 0, sclk_bad = 0, cs_hi_min = 1000000;
    logic [15:0] cap = '0;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_ld = 1'b1, p_mosi = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sclk && cs_n) sclk_bad++;
            if (sclk && (mosi !== p_mosi)) mosi_bad++;
            if (!cs_n && p_cs) begin
                if (frames > 0 && (cyc - t_csr) < cs_hi_min) cs_hi_min = cyc - t_csr;
                frames++;
                t_csf = cyc; nrise = 0; cap = '0; nld = 0;
                hi_min = 1000000; hi_max = 0; lo_min = 1000000; lo_max = 0; lo8 = 0;
            end
            if (sclk && !p_sclk) begin
                if (nrise == 0) dly = cyc - t_csf;
                else if (nrise == 8) lo8 = cyc - t_fall;
                else begin
                    if ((cyc - t_fall) < lo_min) lo_min = cyc - t_fall;
                    if ((cyc - t_fall) > lo_max) lo_max = cyc - t_fall;
                end
                nrise++;
                cap = {cap[14:0], mosi};
                t_rise = cyc;
            end
            if (!sclk && p_sclk) begin
                if ((cyc - t_rise) < hi_min) hi_min = cyc - t_rise;
                if ((cyc - t_rise) > hi_max) hi_max = cyc - t_rise;
                t_fall = cyc;
            end
            if (cs_n && !p_cs) begin
                t_csr = cyc;
                tail = cyc - t_fall;
            end
            if (!load_n && p_ld) begin
                nld++; t_ldf = cyc; ldgap = cyc - t_csr;
            end
            if (load_n && !p_ld) ldw = cyc - t_ldf;
            if (done) begin
                if (done_run == 0) dones++;
                done_run++;
                if (done_run > done_w) done_w = done_run;
            end else begin
                done_run = 0;
            end
        end
        p_cs = cs_n; p_sclk = sclk; p_ld = load_n; p_mosi = mosi;
    end

    // ---------------- stimulus helpers ----------------
    task automatic issue(logic [1:0] ch, logic [7:0] v, logic u, logic d, logic pd, logic sp);
        while (busy) @(negedge clk);
        req_chan = ch; req_value = v; req_update = u; req_defer = d;
        req_pdown = pd; req_split = sp; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(int d0);
        int k = 0;
        while (dones == d0 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic int expw(logic [1:0] ch, logic [7:0] v, logic u, logic d, logic pd);
        return int'({3'b000, pd, u, d, ch[1], ch[0], v});
    endfunction

    task automatic send_and_check(string tag, logic [1:0] ch, logic [7:0] v,
                                  logic u, logic d, logic pd, logic sp);
        int d0 = dones;
        issue(ch, v, u, d, pd, sp);
        wait_done(d0);
        chk({tag, " R2 rise count"}, nrise, 16);
        chk({tag, " R2 word"}, int'(cap), expw(ch, v, u, d, pd));
        chk({tag, " R3 mosi/sclk violations"}, mosi_bad + sclk_bad, 0);
        chk({tag, " R4 high min"}, hi_min, HALF);
        chk({tag, " R4 high max"}, hi_max, HALF);
        chk({tag, " R4 low min"}, lo_min, HALF);
        chk({tag, " R4 low max"}, lo_max, HALF);
        chk({tag, " R5 setup"}, dly, CSS);
        chk({tag, " R5 tail"}, tail, HALF);
        chk({tag, " R6 mid low"}, lo8, sp ? (PAUSE + HALF) : HALF);
        chk({tag, " R7 load pulses"}, nld, (u && d) ? 1 : 0);
        if (u && d) begin
            chk({tag, " R7 load delay"}, ldgap, REC);
            chk({tag, " R7 load width"}, ldw, LDW);
        end
        chk({tag, " R9 done count"}, dones - d0, 1);
        chk({tag, " R9 done width"}, done_w, 1);
        chk({tag, " R9 busy low after"}, int'(busy), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", int'(cs_n), 1);
        chk("R1 sclk in reset", int'(sclk), 0);
        chk("R1 load_n in reset", int'(load_n), 1);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 busy in reset", int'(busy), 1);
        rst_n = 1'b1;
        repeat (PWR - 2) @(negedge clk);
        chk("R1 busy during wait", int'(busy), 1);
        chk("R1 no frame during wait", frames, 0);
        repeat (3) @(negedge clk);
        chk("R1 busy after wait", int'(busy), 0);
    endtask

    task automatic t_basic;
        send_and_check("basic A", 2'b01, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0);
        send_and_check("basic both", 2'b11, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
        send_and_check("basic B pd", 2'b10, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R3 sclk idle", int'(sclk), 0);
    endtask

    task automatic t_split;
        send_and_check("split", 2'b10, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b1);
        send_and_check("split zeros", 2'b00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_defer;
        send_and_check("defer", 2'b11, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0);
        send_and_check("defer split", 2'b01, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b1);
        send_and_check("defer no update", 2'b01, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_gap;
        int f0 = frames;
        cs_hi_min = 1000000;
        send_and_check("gap 1", 2'b01, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0);
        send_and_check("gap 2", 2'b10, 8'hFE, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 frames", frames - f0, 2);
        chk_ge("R8 cs high gap", cs_hi_min, CSW);
    endtask

    task automatic t_busy;
        int d0 = dones;
        int f0 = frames;
        issue(2'b01, 8'h96, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 busy after accept", int'(busy), 1);
        repeat (20) @(negedge clk);
        req_chan = 2'b10; req_value = 8'h69; req_pdown = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(d0);
        chk("R10 one frame", frames - f0, 1);
        chk("R10 word unchanged", int'(cap), expw(2'b01, 8'h96, 1'b1, 1'b0, 1'b0));
        repeat (60) @(negedge clk);
        chk("R10 no late frame", frames - f0, 1);
        chk("R10 idle", int'(busy), 0);
    endtask

    initial begin
        t_reset;
        t_basic;
        t_split;
        t_defer;
        t_gap;
        t_busy;
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!summary_done) begin
            summary_done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule